// File: doc/BRIEF.md
# Flash Chip-Select Address Decoder

This block sits between a memory-mapped access path and a controller for serial flash. Up to four flash devices hang off two buses, each bus carrying two chip selects. Software programs four upper-bound registers, one per device. Together they cut the mapped window into back-to-back regions, so device regions can differ in size. For each request address the block finds the region that holds it. It then reports a one-hot chip select, the device index and the offset of the address inside that region.

Two mode inputs change the decode. With the single-bus input high, only the two devices of the first bus take part. The two upper bounds of the second bus are ignored, and no second-bus chip select ever asserts. With the base-internal input high, the programmed bounds are taken as relative to the window base, and the block adds the base itself. With it low, software has already folded the base into the bounds. When every device gets a region of equal size S, the bounds read base+S, base+2S, base+3S and base+4S in device order. Device n then starts at base + n·S.

The result is registered. It appears one cycle after the request strobe, together with a valid strobe.

Top module: `flash_cs_decoder`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata` into the bound register picked by `cfg_sel`: 0 is bus-A device 0, 1 is bus-A device 1, 2 is bus-B device 0, 3 is bus-B device 1. A request issued in any later cycle is decoded against the new value.
- R2: After reset all four bounds read zero and both response outputs `rsp_valid` and `rsp_cs` are low. A request made before any bound is programmed reports out-of-range.
- R3: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. In a cycle where `rsp_valid` is low, `rsp_cs` is all zero.
- R4: The selected device is the first one, in the order 0, 1, 2, 3, whose effective bound is strictly above the request address. Bit i of `rsp_cs` and the value i on `rsp_dev` identify device i.
- R5: An address equal to a device's effective bound belongs to the next device, or is out of range if that bound is the last active one.
- R6: An address at or above the last active effective bound, or below `base_addr`, gives `rsp_oor` = 1, `rsp_cs` = 0, `rsp_dev` = 0 and `rsp_offset` = 0.
- R7: `rsp_offset` is the request address minus the lower bound of the selected region. The lower bound is `base_addr` for device 0 and the effective bound of device n-1 for device n.
- R8: With `single_bus` high, only devices 0 and 1 are decoded. The device-1 bound is the last active one, and `rsp_cs[3:2]` stays zero.
- R9: With `base_internal` high, each effective bound is the programmed value plus `base_addr`. The sum keeps its carry bit, so a bound that passes the top of the address space lies above every address.
- R10: `rsp_cs` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Bound register write enable |
| cfg_sel | input | 2 | Bound register select (0..3 = A0, A1, B0, B1) |
| cfg_wdata | input | AW | Bound value to write |
| single_bus | input | 1 | Decode only the two bus-A devices |
| base_internal | input | 1 | Add `base_addr` to the programmed bounds |
| base_addr | input | AW | Start of the mapped window |
| req_valid | input | 1 | Request strobe |
| req_addr | input | AW | Request address |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_cs | output | 4 | One-hot chip select |
| rsp_dev | output | 2 | Selected device index |
| rsp_offset | output | AW | Address relative to the selected region |
| rsp_oor | output | 1 | Address outside every active region |

## Verification
The bench builds the block with `AW` = 16 instead of the 32-bit default. A 16-bit width lets a base near the top of the space plus a programmed bound pass the top of the address range. That makes the carry-keeping sum of R9 observable with small, readable addresses. The same narrow width lets one fixed set of 1 KiB-spaced bounds reach every region edge in all four combinations of the two mode inputs.

// File: rtl/flash_dec_pkg.sv
package flash_dec_pkg;
    localparam int unsigned NUM_DEV       = 4;
    localparam int unsigned DEV_IDX_W     = $clog2(NUM_DEV);
    localparam int unsigned DEVS_PER_BUS  = 2;
endpackage

// File: rtl/fdec_thr_regs.sv
module fdec_thr_regs
    import flash_dec_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [DEV_IDX_W-1:0]             sel,
    input  logic [AW-1:0]                    wdata,
    output logic [NUM_DEV-1:0][AW-1:0]       thr
);
    logic [NUM_DEV-1:0][AW-1:0] thr_d, thr_q;

    always_comb begin
        thr_d = thr_q;
        if (we) begin
            thr_d[sel] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= '0;
        end else begin
            thr_q <= thr_d;
        end
    end

    assign thr = thr_q;

    // R1: the written bound is held in the selected slot after the write
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> thr_q[$past(sel)] == $past(wdata));

endmodule

// File: rtl/fdec_region_match.sv
module fdec_region_match
    import flash_dec_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [NUM_DEV-1:0][AW-1:0] thr,
    input  logic [AW-1:0]              base,
    input  logic                       base_internal,
    input  logic                       single_bus,
    input  logic [AW-1:0]              addr,
    output logic                       hit,
    output logic [DEV_IDX_W-1:0]       dev,
    output logic [AW-1:0]              offset
);
    localparam int unsigned EW = AW + 1;

    logic [NUM_DEV-1:0][EW-1:0] eff;
    logic [NUM_DEV-1:0][EW-1:0] lower;
    logic [NUM_DEV-1:0]         below;
    logic [EW-1:0]              addr_x;
    logic [EW-1:0]              base_x;
    logic [EW-1:0]              sel_lower;

    assign addr_x = {1'b0, addr};
    assign base_x = {1'b0, base};

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        localparam bit ON_B = (g >= DEVS_PER_BUS);
        assign eff[g]   = base_internal ? ({1'b0, thr[g]} + base_x) : {1'b0, thr[g]};
        assign below[g] = !(ON_B && single_bus) && (addr_x < eff[g]);
        if (g == 0) begin : g_first
            assign lower[g] = base_x;
        end else begin : g_rest
            assign lower[g] = eff[g-1];
        end
    end

    always_comb begin
        hit       = 1'b0;
        dev       = '0;
        sel_lower = base_x;
        if (addr_x >= base_x) begin
            for (int i = NUM_DEV - 1; i >= 0; i--) begin
                if (below[i]) begin
                    hit       = 1'b1;
                    dev       = DEV_IDX_W'(i);
                    sel_lower = lower[i];
                end
            end
        end
        offset = hit ? (addr - sel_lower[AW-1:0]) : '0;
    end

endmodule

// File: rtl/flash_cs_decoder.sv
module flash_cs_decoder
    import flash_dec_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_sel,
    input  logic [AW-1:0]        cfg_wdata,
    input  logic                 single_bus,
    input  logic                 base_internal,
    input  logic [AW-1:0]        base_addr,
    input  logic                 req_valid,
    input  logic [AW-1:0]        req_addr,
    output logic                 rsp_valid,
    output logic [3:0]           rsp_cs,
    output logic [1:0]           rsp_dev,
    output logic [AW-1:0]        rsp_offset,
    output logic                 rsp_oor
);
    typedef struct packed {
        logic                 vld;
        logic [NUM_DEV-1:0]   cs;
        logic [DEV_IDX_W-1:0] dev;
        logic [AW-1:0]        off;
        logic                 oor;
    } rsp_t;

    logic [NUM_DEV-1:0][AW-1:0] thr;
    logic                       m_hit;
    logic [DEV_IDX_W-1:0]       m_dev;
    logic [AW-1:0]              m_off;
    rsp_t                       rsp_d, rsp_q;

    fdec_thr_regs #(.AW(AW)) u_thr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .thr   (thr)
    );

    fdec_region_match #(.AW(AW)) u_match (
        .thr           (thr),
        .base          (base_addr),
        .base_internal (base_internal),
        .single_bus    (single_bus),
        .addr          (req_addr),
        .hit           (m_hit),
        .dev           (m_dev),
        .offset        (m_off)
    );

    always_comb begin
        rsp_d     = rsp_q;
        rsp_d.vld = req_valid;
        rsp_d.cs  = '0;
        if (req_valid) begin
            rsp_d.oor = !m_hit;
            rsp_d.dev = m_hit ? m_dev : '0;
            rsp_d.off = m_hit ? m_off : '0;
            rsp_d.cs  = m_hit ? (NUM_DEV'(1) << m_dev) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid  = rsp_q.vld;
    assign rsp_cs     = rsp_q.cs;
    assign rsp_dev    = rsp_q.dev;
    assign rsp_offset = rsp_q.off;
    assign rsp_oor    = rsp_q.oor;

    // R3: response strobe follows the request by one cycle
    a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R3: no request, no response and no chip select
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_cs == '0));
    // R10: at most one chip select
    a_r10_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_cs));
    // R6: out-of-range drives no chip select
    a_r6_oor_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_oor) |-> rsp_cs == '0);
    // R8: single-bus requests never reach the second bus
    a_r8_b_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && single_bus) |=> rsp_cs[NUM_DEV-1:DEVS_PER_BUS] == '0);
    // R4: an in-range response selects the device it names
    a_r4_dev_matches_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_oor) |-> rsp_cs[rsp_dev]);

endmodule

// File: tb/flash_cs_decoder_tb_top.sv
`timescale 1ns/1ps
module flash_cs_decoder_tb_top;
    localparam int unsigned AW = 16;
    localparam int NVEC = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          single_bus = 1'b0;
    logic          base_internal = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid;
    logic [3:0]    rsp_cs;
    logic [1:0]    rsp_dev;
    logic [AW-1:0] rsp_offset;
    logic          rsp_oor;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    flash_cs_decoder #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .single_bus(single_bus),
        .base_internal(base_internal), .base_addr(base_addr),
        .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .rsp_cs(rsp_cs), .rsp_dev(rsp_dev), .rsp_offset(rsp_offset),
        .rsp_oor(rsp_oor)
    );

    // {single, base_internal, addr, oor, dev, offset}; base 0x1000,
    // bounds 0x1400 0x1800 0x1C00 0x2000
    localparam logic [36:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 16'h1000, 1'b0, 2'd0, 16'h0000},   // R4
        {1'b0, 1'b0, 16'h13FF, 1'b0, 2'd0, 16'h03FF},   // R7
        {1'b0, 1'b0, 16'h1400, 1'b0, 2'd1, 16'h0000},   // R5
        {1'b0, 1'b0, 16'h1ABC, 1'b0, 2'd2, 16'h02BC},   // R4
        {1'b0, 1'b0, 16'h1FFF, 1'b0, 2'd3, 16'h03FF},   // R4
        {1'b0, 1'b0, 16'h2000, 1'b1, 2'd0, 16'h0000},   // R6
        {1'b0, 1'b0, 16'h0FFF, 1'b1, 2'd0, 16'h0000},   // R6
        {1'b1, 1'b0, 16'h17FF, 1'b0, 2'd1, 16'h03FF},   // R8
        {1'b1, 1'b0, 16'h1800, 1'b1, 2'd0, 16'h0000},   // R8
        {1'b1, 1'b0, 16'h1C10, 1'b1, 2'd0, 16'h0000},   // R8
        {1'b0, 1'b1, 16'h2400, 1'b0, 2'd1, 16'h0000},   // R9
        {1'b0, 1'b1, 16'h23FF, 1'b0, 2'd0, 16'h13FF},   // R9
        {1'b0, 1'b1, 16'h2FFF, 1'b0, 2'd3, 16'h03FF},   // R9
        {1'b0, 1'b1, 16'h3000, 1'b1, 2'd0, 16'h0000},   // R9
        {1'b1, 1'b1, 16'h27FF, 1'b0, 2'd1, 16'h03FF},   // R8
        {1'b1, 1'b1, 16'h2800, 1'b1, 2'd0, 16'h0000}    // R8
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_bound(input logic [1:0] s, input logic [AW-1:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [AW-1:0] a, input logic sb, input logic bi);
        @(negedge clk);
        req_addr = a; single_bus = sb; base_internal = bi; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string req, input logic oor,
                              input logic [1:0] dev, input logic [AW-1:0] off);
        chk(req, "valid", 32'(rsp_valid), 32'd1);
        chk(req, "oor", 32'(rsp_oor), 32'(oor));
        chk(req, "cs", 32'(rsp_cs), oor ? 32'd0 : (32'd1 << dev));
        chk(req, "dev", 32'(rsp_dev), oor ? 32'd0 : 32'(dev));
        chk(req, "offset", 32'(rsp_offset), 32'(off));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: idle outputs after reset
        chk("R2", "valid after reset", 32'(rsp_valid), 32'd0);
        chk("R2", "cs after reset", 32'(rsp_cs), 32'd0);
        base_addr = 16'h1000;
        // R2: unprogrammed bounds give out-of-range in both base modes
        send(16'h1000, 1'b0, 1'b0);
        expect_rsp("R2", 1'b1, 2'd0, 16'h0);
        send(16'h0800, 1'b0, 1'b1);
        expect_rsp("R2", 1'b1, 2'd0, 16'h0);
        // R1: program bounds
        wr_bound(2'd0, 16'h1400);
        wr_bound(2'd1, 16'h1800);
        wr_bound(2'd2, 16'h1C00);
        wr_bound(2'd3, 16'h2000);
        for (int i = 0; i < NVEC; i++) begin
            send(VEC[i][34:19], VEC[i][36], VEC[i][35]);
            expect_rsp($sformatf("R4/R5/R6/R7/R8/R9/R10 vec%0d", i),
                       VEC[i][18], VEC[i][17:16], VEC[i][15:0]);
        end
        // R3: no request means no strobe and no chip select
        @(negedge clk);
        chk("R3", "valid idle", 32'(rsp_valid), 32'd0);
        chk("R3", "cs idle", 32'(rsp_cs), 32'd0);
        // R1: rewriting device 0 bound moves the region edge
        wr_bound(2'd0, 16'h1200);
        send(16'h1300, 1'b0, 1'b0);
        expect_rsp("R1", 1'b0, 2'd1, 16'h0100);
        // R9: bound plus base passes the top of the space, carry kept
        base_addr = 16'hF000;
        wr_bound(2'd0, 16'h2000);
        send(16'hFFFF, 1'b0, 1'b1);
        expect_rsp("R9", 1'b0, 2'd0, 16'h0FFF);
        // R3: back-to-back requests keep the strobe high
        @(negedge clk);
        req_addr = 16'hF010; single_bus = 1'b0; base_internal = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_addr = 16'hF020;
        chk("R3", "first offset", 32'(rsp_offset), 32'h0010);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R3", "second valid", 32'(rsp_valid), 32'd1);
        chk("R3", "second offset", 32'(rsp_offset), 32'h0020);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule